// File: doc/BRIEF.md
# Floppy Controller Host Data Port

This block is the processor-facing side of a floppy disk controller model. A command engine, which sits outside the block, receives command codes, fills a sector buffer one byte at a time and sets a stored status value. The processor, or a DMA engine acting for it, then moves bytes through a data register. Each data access consumes one buffer position.

The busy and data-request status bits are not driven by a timer. They come straight from the buffer fill level: they stay set while the read/write pointer is below the buffer length. Moving the final byte in either direction raises an interrupt latch. An edge flag beside the latch marks a fresh interrupt, one raised while nothing was already pending. Reading status clears both the latch and the edge flag. Writing a command clears the latch and empties the buffer.

Top module: `fdc_host_port`

## Requirements
- R1: After reset the status read is 0x00, the interrupt level output is 0, the edge flag is 0, data request is 0, and a data read returns 0xFF.
- R2: The register index is taken from bus address bits 2:1. Index 0 is status on read and command on write, 1 is track, 2 is sector and 3 is data. Track and sector read back the last value written.
- R3: A data read while data remains returns the byte at the pointer and advances the pointer by one. On an empty buffer a data read returns 0xFF and leaves the pointer where it is.
- R4: Status bit 0 (busy) is set while pointer < length. For a command whose bit 7 is 1 (data-request command), the stored bits 1:0 are replaced and bit 1 also equals pointer < length, and the data request output follows the same condition. For a command whose bit 7 is 0 (seek command), only stored bit 0 is replaced and bit 1 passes through.
- R5: A data read or a data write of the final byte (pointer = length - 1) raises the interrupt latch.
- R6: When the latch is raised, the edge flag is set if the latch was clear. If the latch was already set, the edge flag keeps its value.
- R7: A status read clears the latch and the edge flag. A raise that falls in the same cycle wins, and leaves latch = 1 and edge = 1.
- R8: A data write stores the byte at the pointer and advances the pointer only while pointer < length. Otherwise it is ignored.
- R9: A command write clears the latch and leaves the edge flag alone. It sets pointer and length to zero. In the next cycle it pulses the command-start output with the code, unless R10 or R11 applies.
- R10: A command with upper nibble 0xD (force interrupt) clears the stored status, empties the buffer and raises the latch. It does not pulse the command-start output.
- R11: A data-request command written while no medium is present sets the stored status to 0x80 and does not pulse the command-start output. A seek command still starts regardless of the medium.
- R12: The interrupt level output equals parameter IRQ_LEVEL (default 2) while the latch is set, and 0 otherwise.
- R13: An engine fill appends a byte at the current length and increments the length. The fill is ignored when the buffer holds DEPTH bytes. A fill and a host data read in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Bus address bits 2:1, the register index |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| medium_ok | input | 1 | A medium is present in the drive |
| eng_fill_vld | input | 1 | Engine appends one byte to the buffer |
| eng_fill_data | input | 8 | Byte to append |
| eng_stat_we | input | 1 | Engine writes the stored status |
| eng_stat_val | input | 8 | Stored status value |
| eng_irq | input | 1 | Engine raises the interrupt (for example, seek done) |
| eng_peek_idx | input | log2(DEPTH) | Buffer index the engine inspects |
| eng_peek_data | output | 8 | Buffer byte at eng_peek_idx |
| cmd_go | output | 1 | One-cycle command start pulse |
| cmd_code | output | 8 | Code of the started command |
| track_q | output | 8 | Track register |
| sector_q | output | 8 | Sector register |
| drq | output | 1 | Data request for a DMA engine |
| irq_ipl | output | 3 | Interrupt priority level to the processor |
| irq_edge | output | 1 | Edge flag: interrupt raised with none pending |

## Verification
There are two places where two functions land in one cycle. The first is the interrupt path. A status read, which clears the latch, is issued in the same cycle as an engine interrupt raise; afterwards the bench expects latch and edge flag both set. The second is the buffer. A host data read that consumes the last stored byte is issued in the same cycle as an engine fill. The bench expects the old byte returned, the interrupt raised, and the new byte readable on the next access.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef enum logic [1:0] {
    RIX_CMDSTAT = 2'd0,
    RIX_TRACK   = 2'd1,
    RIX_SECTOR  = 2'd2,
    RIX_DATA    = 2'd3
  } reg_idx_e;

  localparam logic [7:0] ST_NO_MEDIUM = 8'h80;
  localparam logic [3:0] OP_FORCE     = 4'hD;
  localparam logic [7:0] EMPTY_BYTE   = 8'hFF;

  // Live status: the stored value with the fill-level bits inserted.
  function automatic logic [7:0] compose_status(input logic [7:0] stored,
                                                input logic       drq_cmd,
                                                input logic       pending);
    logic [7:0] s;
    if (drq_cmd) begin
      s    = stored & 8'hFC;
      s[1] = pending;
    end else begin
      s    = stored & 8'hFE;
    end
    s[0] = pending;
    return s;
  endfunction

  // Edge flag update, given the latch and flag after this cycle's clears.
  function automatic logic next_edge(input logic raise,
                                     input logic latch_kept,
                                     input logic edge_kept);
    if (!raise) return edge_kept;
    return latch_kept ? edge_kept : 1'b1;
  endfunction

  function automatic logic is_seek(input logic [7:0] cmd);
    return !cmd[7];
  endfunction

  function automatic logic is_force(input logic [7:0] cmd);
    return cmd[7:4] == OP_FORCE;
  endfunction

endpackage

// File: rtl/fdc_sector_buf.sv
module fdc_sector_buf #(
  parameter int DEPTH = 512,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  input  logic             fill_vld,
  input  logic [7:0]       fill_data,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [7:0]       peek_data,
  output logic [7:0]       rd_byte,
  output logic             avail,
  output logic             last_xfer,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] len_q
);
  import fdc_pkg::*;

  localparam logic [PTR_W-1:0] FULL_LEN = PTR_W'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       fill_take;
  logic       host_take;

  assign avail     = ptr_q < len_q;
  assign host_take = (host_rd || host_wr) && avail && !flush;
  assign last_xfer = host_take && ((ptr_q + PTR_W'(1)) == len_q);
  assign fill_take = fill_vld && !flush && (len_q != FULL_LEN);
  assign rd_byte   = avail ? mem[ptr_q[IDX_W-1:0]] : EMPTY_BYTE;
  assign peek_data = mem[peek_idx];

  always_ff @(posedge clk) begin
    if (fill_take) mem[len_q[IDX_W-1:0]] <= fill_data;
    if (host_wr && host_take) mem[ptr_q[IDX_W-1:0]] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      len_q <= '0;
    end else if (flush) begin
      ptr_q <= '0;
      len_q <= '0;
    end else begin
      if (host_take) ptr_q <= ptr_q + PTR_W'(1);
      if (fill_take) len_q <= len_q + PTR_W'(1);
    end
  end

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= len_q && len_q <= FULL_LEN);                                // R8
  AST_EMPTY_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !avail && !flush |=> $stable(ptr_q));                     // R3
  AST_WR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && avail && !flush |=> ptr_q == $past(ptr_q) + PTR_W'(1));   // R8

endmodule

// File: rtl/fdc_irq_ctl.sv
module fdc_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clr_latch,
  input  logic clr_all,
  output logic latch_q,
  output logic edge_q
);
  import fdc_pkg::*;

  logic latch_kept;
  logic edge_kept;

  assign latch_kept = latch_q && !clr_latch && !clr_all;
  assign edge_kept  = edge_q && !clr_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      edge_q  <= 1'b0;
    end else begin
      latch_q <= raise || latch_kept;
      edge_q  <= next_edge(raise, latch_kept, edge_kept);
    end
  end

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> latch_q);                                                  // R5
  AST_FRESH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    raise && !latch_q |=> edge_q);                                       // R6
  AST_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    raise && latch_q && !clr_latch && !clr_all |=> edge_q == $past(edge_q)); // R6
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all && !raise |=> !latch_q && !edge_q);                          // R7

endmodule

// File: rtl/fdc_cmd_ctl.sv
module fdc_cmd_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_val,
  input  logic       medium_ok,
  input  logic       eng_stat_we,
  input  logic [7:0] eng_stat_val,
  output logic [7:0] stat_q,
  output logic       drq_cmd_q,
  output logic       force_evt,
  output logic       go_q,
  output logic [7:0] code_q
);
  import fdc_pkg::*;

  logic blocked;

  assign force_evt = cmd_wr && is_force(cmd_val);
  assign blocked   = !is_seek(cmd_val) && !medium_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q    <= '0;
      drq_cmd_q <= 1'b0;
      go_q      <= 1'b0;
      code_q    <= '0;
    end else begin
      go_q <= 1'b0;
      if (cmd_wr) begin
        drq_cmd_q <= !is_seek(cmd_val);
        if (force_evt) begin
          stat_q <= '0;
        end else if (blocked) begin
          stat_q <= ST_NO_MEDIUM;
        end else begin
          go_q   <= 1'b1;
          code_q <= cmd_val;
        end
      end else if (eng_stat_we) begin
        stat_q <= eng_stat_val;
      end
    end
  end

  AST_FORCE_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
    force_evt |=> !go_q && stat_q == 8'h00);                             // R10
  AST_NOMEDIUM: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !force_evt && blocked |=> !go_q && stat_q == ST_NO_MEDIUM); // R11
  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_q && !cmd_wr |=> !go_q);                                          // R9

endmodule

// File: rtl/fdc_host_port.sv
module fdc_host_port #(
  parameter int DEPTH     = 512,
  parameter int IPL_W     = 3,
  parameter int IRQ_LEVEL = 2,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int PTR_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:1]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             medium_ok,
  input  logic             eng_fill_vld,
  input  logic [7:0]       eng_fill_data,
  input  logic             eng_stat_we,
  input  logic [7:0]       eng_stat_val,
  input  logic             eng_irq,
  input  logic [IDX_W-1:0] eng_peek_idx,
  output logic [7:0]       eng_peek_data,
  output logic             cmd_go,
  output logic [7:0]       cmd_code,
  output logic [7:0]       track_q,
  output logic [7:0]       sector_q,
  output logic             drq,
  output logic [IPL_W-1:0] irq_ipl,
  output logic             irq_edge
);
  import fdc_pkg::*;

  reg_idx_e         idx;
  logic             stat_rd_evt;
  logic             cmd_wr_evt;
  logic             data_rd_evt;
  logic             data_wr_evt;
  logic             raise_evt;
  logic             force_evt;
  logic             last_evt;
  logic             avail;
  logic             irq_latch;
  logic             drq_cmd;
  logic [7:0]       stat_stored;
  logic [7:0]       data_byte;
  logic [PTR_W-1:0] buf_ptr;
  logic [PTR_W-1:0] buf_len;

  assign idx         = reg_idx_e'(bus_addr);
  assign stat_rd_evt = bus_rd && idx == RIX_CMDSTAT;
  assign cmd_wr_evt  = bus_wr && idx == RIX_CMDSTAT;
  assign data_rd_evt = bus_rd && idx == RIX_DATA;
  assign data_wr_evt = bus_wr && idx == RIX_DATA;
  assign raise_evt   = last_evt || force_evt || eng_irq;

  fdc_sector_buf #(.DEPTH(DEPTH)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (cmd_wr_evt),
    .host_rd    (data_rd_evt),
    .host_wr    (data_wr_evt),
    .host_wdata (bus_wdata),
    .fill_vld   (eng_fill_vld),
    .fill_data  (eng_fill_data),
    .peek_idx   (eng_peek_idx),
    .peek_data  (eng_peek_data),
    .rd_byte    (data_byte),
    .avail      (avail),
    .last_xfer  (last_evt),
    .ptr_q      (buf_ptr),
    .len_q      (buf_len)
  );

  fdc_cmd_ctl u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr_evt),
    .cmd_val      (bus_wdata),
    .medium_ok    (medium_ok),
    .eng_stat_we  (eng_stat_we),
    .eng_stat_val (eng_stat_val),
    .stat_q       (stat_stored),
    .drq_cmd_q    (drq_cmd),
    .force_evt    (force_evt),
    .go_q         (cmd_go),
    .code_q       (cmd_code)
  );

  fdc_irq_ctl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise     (raise_evt),
    .clr_latch (cmd_wr_evt),
    .clr_all   (stat_rd_evt),
    .latch_q   (irq_latch),
    .edge_q    (irq_edge)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track_q  <= '0;
      sector_q <= '0;
    end else if (bus_wr) begin
      if (idx == RIX_TRACK)  track_q  <= bus_wdata;
      if (idx == RIX_SECTOR) sector_q <= bus_wdata;
    end
  end

  always_comb begin
    unique case (idx)
      RIX_CMDSTAT: bus_rdata = compose_status(stat_stored, drq_cmd, avail);
      RIX_TRACK:   bus_rdata = track_q;
      RIX_SECTOR:  bus_rdata = sector_q;
      default:     bus_rdata = data_byte;
    endcase
  end

  assign drq     = drq_cmd && avail;
  assign irq_ipl = irq_latch ? IPL_W'(IRQ_LEVEL) : '0;

  AST_CMD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_evt |=> buf_ptr == '0 && buf_len == '0);                      // R9
  AST_FORCE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    force_evt |=> irq_ipl == IPL_W'(IRQ_LEVEL));                         // R10
  AST_LAST_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> irq_ipl != '0 && buf_ptr == $past(buf_len));            // R5
  AST_IPL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_evt && (stat_rd_evt || cmd_wr_evt) |=> irq_ipl == '0);        // R12

endmodule

// File: tb/fdc_host_port_tb.sv
module fdc_host_port_tb;
  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:1]       bus_addr = '0;
  logic             bus_rd = 1'b0;
  logic             bus_wr = 1'b0;
  logic [7:0]       bus_wdata = '0;
  logic [7:0]       bus_rdata;
  logic             medium_ok = 1'b1;
  logic             eng_fill_vld = 1'b0;
  logic [7:0]       eng_fill_data = '0;
  logic             eng_stat_we = 1'b0;
  logic [7:0]       eng_stat_val = '0;
  logic             eng_irq = 1'b0;
  logic [IDX_W-1:0] eng_peek_idx = '0;
  logic [7:0]       eng_peek_data;
  logic             cmd_go;
  logic [7:0]       cmd_code;
  logic [7:0]       track_q;
  logic [7:0]       sector_q;
  logic             drq;
  logic [2:0]       irq_ipl;
  logic             irq_edge;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [1:0] IX_ST = 2'd0, IX_TRK = 2'd1, IX_SEC = 2'd2, IX_DAT = 2'd3;

  fdc_host_port #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .medium_ok(medium_ok),
    .eng_fill_vld(eng_fill_vld), .eng_fill_data(eng_fill_data),
    .eng_stat_we(eng_stat_we), .eng_stat_val(eng_stat_val), .eng_irq(eng_irq),
    .eng_peek_idx(eng_peek_idx), .eng_peek_data(eng_peek_data),
    .cmd_go(cmd_go), .cmd_code(cmd_code), .track_q(track_q), .sector_q(sector_q),
    .drq(drq), .irq_ipl(irq_ipl), .irq_edge(irq_edge)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic bus_read(input logic [1:0] ix, output logic [7:0] d);
    bus_addr = ix; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] ix, input logic [7:0] v);
    bus_addr = ix; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic fill(input logic [7:0] v);
    eng_fill_vld = 1'b1; eng_fill_data = v;
    @(negedge clk); eng_fill_vld = 1'b0;
  endtask

  task automatic set_stat(input logic [7:0] v);
    eng_stat_we = 1'b1; eng_stat_val = v;
    @(negedge clk); eng_stat_we = 1'b0;
  endtask

  task automatic pulse_irq();
    eng_irq = 1'b1;
    @(negedge clk); eng_irq = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_read(IX_ST, d);  check("R1 status", d, 8'h00);
    check("R1 ipl", irq_ipl, 0);
    check("R1 edge", irq_edge, 0);
    check("R1 drq", drq, 0);
    bus_read(IX_DAT, d); check("R1 data", d, 8'hFF);
  endtask

  task automatic t_index();
    logic [7:0] d;
    bus_write(IX_TRK, 8'h27);
    bus_write(IX_SEC, 8'h09);
    bus_read(IX_TRK, d); check("R2 track", d, 8'h27);
    bus_read(IX_SEC, d); check("R2 sector", d, 8'h09);
    check("R2 track_q", track_q, 8'h27);
  endtask

  task automatic t_read_flow();
    logic [7:0] d;
    bus_write(IX_ST, 8'h88);
    check("R9 go", cmd_go, 1); check("R9 code", cmd_code, 8'h88);
    set_stat(8'h23);
    check("R9 go pulse ends", cmd_go, 0);
    fill(8'hA1); fill(8'hB2); fill(8'hC3);
    check("R4 drq set", drq, 1);
    bus_read(IX_ST, d);  check("R4 drq status", d, 8'h23);
    bus_read(IX_DAT, d); check("R3 byte0", d, 8'hA1);
    check("R5 no early irq", irq_ipl, 0);
    bus_read(IX_DAT, d); check("R3 byte1", d, 8'hB2);
    bus_read(IX_DAT, d); check("R3 byte2", d, 8'hC3);
    check("R5 R12 ipl", irq_ipl, 2); check("R6 edge", irq_edge, 1);
    check("R4 drq clear", drq, 0);
    bus_read(IX_ST, d);  check("R4 idle status", d, 8'h20);
    check("R7 ipl cleared", irq_ipl, 0); check("R7 edge cleared", irq_edge, 0);
    bus_read(IX_DAT, d); check("R3 empty", d, 8'hFF);
    bus_read(IX_ST, d);  check("R3 no advance", d, 8'h20);
  endtask

  task automatic t_write_flow();
    logic [7:0] d;
    bus_write(IX_ST, 8'hA8);
    fill(8'h00); fill(8'h00);
    bus_write(IX_DAT, 8'h5A);
    eng_peek_idx = 0; #1 check("R8 store0", eng_peek_data, 8'h5A);
    check("R5 no early irq wr", irq_ipl, 0);
    bus_write(IX_DAT, 8'h6B);
    eng_peek_idx = 1; #1 check("R8 store1", eng_peek_data, 8'h6B);
    check("R5 write irq", irq_ipl, 2);
    bus_write(IX_DAT, 8'h7C);
    #1 check("R8 ignored", eng_peek_data, 8'h6B);
    bus_read(IX_ST, d); check("R8 busy clear", d[0], 0);
  endtask

  task automatic t_nodrq();
    logic [7:0] d;
    bus_write(IX_ST, 8'h10);
    check("R9 seek go", cmd_go, 1);
    set_stat(8'h07); fill(8'h44);
    check("R4 no drq out", drq, 0);
    bus_read(IX_ST, d);  check("R4 seek busy", d, 8'h07);
    bus_read(IX_DAT, d); check("R3 seek byte", d, 8'h44);
    bus_read(IX_ST, d);  check("R4 seek idle", d, 8'h06);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    bus_read(IX_ST, d);
    pulse_irq();
    check("R6 fresh latch", irq_ipl, 2); check("R6 fresh edge", irq_edge, 1);
    pulse_irq();
    check("R6 pending latch", irq_ipl, 2); check("R6 edge kept", irq_edge, 1);
    bus_write(IX_ST, 8'h10);
    check("R9 latch clear", irq_ipl, 0); check("R9 edge kept", irq_edge, 1);
    pulse_irq();
    check("R6 reraise", irq_edge, 1);
    bus_read(IX_ST, d);
    check("R7 cleared", irq_edge, 0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse_irq();
    bus_addr = IX_ST; bus_rd = 1'b1; eng_irq = 1'b1;
    @(negedge clk); bus_rd = 1'b0; eng_irq = 1'b0;
    check("R7 raise wins latch", irq_ipl, 2); check("R7 raise wins edge", irq_edge, 1);
    bus_read(IX_ST, d);
    bus_write(IX_ST, 8'h88);
    fill(8'h11);
    bus_addr = IX_DAT; bus_rd = 1'b1; eng_fill_vld = 1'b1; eng_fill_data = 8'h22;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; eng_fill_vld = 1'b0;
    check("R13 old byte", d, 8'h11);
    check("R13 R5 last irq", irq_ipl, 2);
    bus_read(IX_DAT, d); check("R13 appended", d, 8'h22);
    bus_read(IX_ST, d);
  endtask

  task automatic t_force();
    logic [7:0] d;
    bus_write(IX_ST, 8'h88);
    set_stat(8'h20); fill(8'h55); fill(8'h66);
    bus_write(IX_ST, 8'hD0);
    check("R10 no go", cmd_go, 0);
    check("R10 irq", irq_ipl, 2);
    bus_read(IX_ST, d);  check("R10 status", d, 8'h00);
    bus_read(IX_DAT, d); check("R10 empty", d, 8'hFF);
  endtask

  task automatic t_nomedium();
    logic [7:0] d;
    medium_ok = 1'b0;
    bus_write(IX_ST, 8'h88);
    check("R11 no go", cmd_go, 0);
    bus_read(IX_ST, d); check("R11 status", d, 8'h80);
    bus_write(IX_ST, 8'h00);
    check("R11 seek go", cmd_go, 1);
    medium_ok = 1'b1;
  endtask

  task automatic t_full();
    logic [7:0] d;
    bus_write(IX_ST, 8'h88);
    for (int i = 0; i <= DEPTH; i++) fill(8'(i + 8'h30));
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(IX_DAT, d); check("R13 full", d, 8'(i + 8'h30));
    end
    bus_read(IX_DAT, d); check("R13 overflow dropped", d, 8'hFF);
    bus_read(IX_ST, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_read_flow();
    t_write_flow();
    t_nodrq();
    t_edge();
    t_collide();
    t_force();
    t_nomedium();
    t_full();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule